// File: doc/BRIEF.md
# Raster Timing Generator

This block walks a video raster one pixel per clock and produces the horizontal and vertical strobes that frame it. A free-running position counter sweeps every pixel of a frame, blanking included. It moves along a line first, then steps to the next line, and returns to the top-left corner after the last pixel of the last line. The counter position leaves the block on `pos_x` and `pos_y`, so that a pixel source can compute the colour for that coordinate.

The strobes come from a separate decoder with two register stages. In the first stage, each axis is classified on its own into one of four segments: `SEG_ACTIVE`, `SEG_FRONT`, `SEG_SYNC` and `SEG_BACK`. The segment register of each axis is a small state machine. Its transitions are named after the boundary crossed:
- active to front when the coordinate reaches the active size;
- front to sync when it passes the front porch;
- sync to back when it passes the pulse width;
- back (or sync, when the back porch is empty) to active when the coordinate wraps.

In the second stage, the two segments are combined into registered `de`, `hsync` and `vsync`. These outputs therefore describe the position that was on `pos_x`/`pos_y` exactly two clocks earlier. A pixel source with two cycles of its own pipeline lines up with them directly.

The frame size, the active size, the porches and the sync widths are all parameters. The polarity of each sync output is a separate parameter.

Top module: `raster_timing_gen`

## Requirements
- R1: While `rst` is high at a clock edge, the block clears `pos_x` and `pos_y` to 0 and drives `de` low. It drives `hsync` and `vsync` to their inactive levels. This also holds when reset is raised in the middle of a frame.
- R2: `pos_x` steps by one every clock from 0 to `FRAME_W-1`, then returns to 0.
- R3: `pos_y` holds while `pos_x` is below `FRAME_W-1`. It advances by one on the clock where `pos_x` wraps, and returns to 0 after `FRAME_H-1`.
- R4: `de` is high exactly when the decoded position has x below `ACT_W` and y below `ACT_H`.
- R5: `hsync` is at its active level exactly when the decoded x is in [`ACT_W+H_FP`, `ACT_W+H_FP+H_SW`).
- R6: `vsync` is at its active level exactly when the decoded y is in [`ACT_H+V_FP`, `ACT_H+V_FP+V_SW`). It depends on y alone, so it only changes together with the decode of x = 0.
- R7: `de`, `hsync` and `vsync` show the position that `pos_x`/`pos_y` held two clocks earlier. After reset is released, the first two clocks show the reset levels.
- R8: When `HS_HIGH` is 1, the active level of `hsync` is 1; when it is 0, the active level is 0. `VS_HIGH` sets the active level of `vsync` in the same way.
- R9: Over each frame, `de` is high for `ACT_W*ACT_H` clocks. Every `hsync` pulse lasts `H_SW` clocks, and every `vsync` pulse lasts `V_SW*FRAME_W` clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| pos_x | output | CW | Current pixel column, blanking included |
| pos_y | output | CW | Current line, blanking included |
| hsync | output | 1 | Horizontal sync, two clocks behind the position |
| vsync | output | 1 | Vertical sync, two clocks behind the position |
| de | output | 1 | Active video strobe, two clocks behind the position |

## Verification
The bench builds two small instances, because a full-size frame would take far too many clocks.

The first instance uses a 20 by 12 raster with a 12 by 6 active area and non-empty porches on both axes. Several whole frames fit in a few hundred clocks, so the bench can count pulse widths and active pixels per frame.

The second instance uses a 10 by 8 raster with empty back porches and both syncs active low. Sync pulses there run right up to the line and frame wrap, which reaches the segment transition from sync straight back to active. The same instance also reaches the inverted polarity path.

// File: rtl/raster_pkg.sv
package raster_pkg;

    // Segment of one raster axis; also the state of each axis classifier.
    typedef enum logic [1:0] {
        SEG_ACTIVE = 2'd0,
        SEG_FRONT  = 2'd1,
        SEG_SYNC   = 2'd2,
        SEG_BACK   = 2'd3
    } seg_t;

endpackage

// File: rtl/raster_pos_counter.sv
module raster_pos_counter #(
    parameter int CW      = 11,
    parameter int FRAME_W = 1650,
    parameter int FRAME_H = 750
) (
    input  logic          clk,
    input  logic          rst,
    output logic [CW-1:0] x_o,
    output logic [CW-1:0] y_o
);

    localparam logic [CW-1:0] X_LAST = CW'(FRAME_W - 1);
    localparam logic [CW-1:0] Y_LAST = CW'(FRAME_H - 1);

    logic [CW-1:0] x_q;
    logic [CW-1:0] y_q;
    logic          line_end;

    assign line_end = (x_q == X_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            x_q <= '0;
            y_q <= '0;
        end else if (line_end) begin
            x_q <= '0;
            y_q <= (y_q == Y_LAST) ? '0 : y_q + CW'(1);
        end else begin
            x_q <= x_q + CW'(1);
        end
    end

    assign x_o = x_q;
    assign y_o = y_q;

    assert_x_bound_R2: assert property (@(posedge clk) disable iff (rst)
        x_q <= X_LAST);

    assert_x_wrap_R2: assert property (@(posedge clk) disable iff (rst)
        (x_q == X_LAST) |=> (x_q == '0));

    assert_y_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (x_q != X_LAST) |=> $stable(y_q));

    assert_y_wrap_R3: assert property (@(posedge clk) disable iff (rst)
        (x_q == X_LAST && y_q == Y_LAST) |=> (y_q == '0));

endmodule

// File: rtl/raster_axis_classify.sv
module raster_axis_classify
    import raster_pkg::*;
#(
    parameter int CW     = 11,
    parameter int ACTIVE = 1280,
    parameter int PORCH  = 110,
    parameter int PULSE  = 40
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] coord_i,
    output seg_t          seg_o
);

    localparam logic [CW-1:0] FRONT_AT = CW'(ACTIVE);
    localparam logic [CW-1:0] SYNC_AT  = CW'(ACTIVE + PORCH);
    localparam logic [CW-1:0] BACK_AT  = CW'(ACTIVE + PORCH + PULSE);

    seg_t seg_q;
    seg_t seg_d;

    // Next segment from the incoming coordinate.
    always_comb begin
        if (coord_i < FRONT_AT) begin
            seg_d = SEG_ACTIVE;
        end else if (coord_i < SYNC_AT) begin
            seg_d = SEG_FRONT;
        end else if (coord_i < BACK_AT) begin
            seg_d = SEG_SYNC;
        end else begin
            seg_d = SEG_BACK;
        end
    end

    // State register: blanking segment out of reset.
    always_ff @(posedge clk) begin
        if (rst) begin
            seg_q <= SEG_BACK;
        end else begin
            seg_q <= seg_d;
        end
    end

    assign seg_o = seg_q;

    // Segments only ever advance in raster order or return to active.
    assert_seg_order_R7: assert property (@(posedge clk) disable iff (rst)
        (seg_q == SEG_ACTIVE) |=> (seg_q == SEG_ACTIVE || seg_q == SEG_FRONT
                                   || (PORCH == 0 && seg_q == SEG_SYNC)));

endmodule

// File: rtl/raster_strobe_out.sv
module raster_strobe_out
    import raster_pkg::*;
#(
    parameter bit HS_HIGH = 1'b1,
    parameter bit VS_HIGH = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  seg_t h_seg_i,
    input  seg_t v_seg_i,
    output logic hsync_o,
    output logic vsync_o,
    output logic de_o
);

    logic h_vis;
    logic h_pulse;
    logic v_vis;
    logic v_pulse;
    logic hsync_q;
    logic vsync_q;
    logic de_q;

    always_comb begin
        unique case (h_seg_i)
            SEG_ACTIVE: begin h_vis = 1'b1; h_pulse = 1'b0; end
            SEG_FRONT:  begin h_vis = 1'b0; h_pulse = 1'b0; end
            SEG_SYNC:   begin h_vis = 1'b0; h_pulse = 1'b1; end
            SEG_BACK:   begin h_vis = 1'b0; h_pulse = 1'b0; end
            default:    begin h_vis = 1'b0; h_pulse = 1'b0; end
        endcase
    end

    always_comb begin
        unique case (v_seg_i)
            SEG_ACTIVE: begin v_vis = 1'b1; v_pulse = 1'b0; end
            SEG_FRONT:  begin v_vis = 1'b0; v_pulse = 1'b0; end
            SEG_SYNC:   begin v_vis = 1'b0; v_pulse = 1'b1; end
            SEG_BACK:   begin v_vis = 1'b0; v_pulse = 1'b0; end
            default:    begin v_vis = 1'b0; v_pulse = 1'b0; end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            de_q    <= 1'b0;
            hsync_q <= ~HS_HIGH;
            vsync_q <= ~VS_HIGH;
        end else begin
            de_q    <= h_vis & v_vis;
            hsync_q <= h_pulse ? HS_HIGH : ~HS_HIGH;
            vsync_q <= v_pulse ? VS_HIGH : ~VS_HIGH;
        end
    end

    assign de_o    = de_q;
    assign hsync_o = hsync_q;
    assign vsync_o = vsync_q;

    // Active video never overlaps a sync pulse.
    assert_de_no_hsync_R4: assert property (@(posedge clk) disable iff (rst)
        de_q |-> (hsync_q == ~HS_HIGH));

    assert_de_no_vsync_R4: assert property (@(posedge clk) disable iff (rst)
        de_q |-> (vsync_q == ~VS_HIGH));

endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
    import raster_pkg::*;
#(
    parameter int CW      = 11,
    parameter int FRAME_W = 1650,
    parameter int FRAME_H = 750,
    parameter int ACT_W   = 1280,
    parameter int ACT_H   = 720,
    parameter int H_FP    = 110,
    parameter int H_SW    = 40,
    parameter int V_FP    = 5,
    parameter int V_SW    = 5,
    parameter bit HS_HIGH = 1'b1,
    parameter bit VS_HIGH = 1'b1
) (
    input  logic          clk,
    input  logic          rst,
    output logic [CW-1:0] pos_x,
    output logic [CW-1:0] pos_y,
    output logic          hsync,
    output logic          vsync,
    output logic          de
);

    localparam logic [CW-1:0] X_ACT   = CW'(ACT_W);
    localparam logic [CW-1:0] Y_ACT   = CW'(ACT_H);
    localparam logic [CW-1:0] HS_FROM = CW'(ACT_W + H_FP);
    localparam logic [CW-1:0] HS_TO   = CW'(ACT_W + H_FP + H_SW);
    localparam logic [CW-1:0] VS_FROM = CW'(ACT_H + V_FP);
    localparam logic [CW-1:0] VS_TO   = CW'(ACT_H + V_FP + V_SW);

    logic [CW-1:0] x_w;
    logic [CW-1:0] y_w;
    seg_t          h_seg;
    seg_t          v_seg;

    raster_pos_counter #(
        .CW      (CW),
        .FRAME_W (FRAME_W),
        .FRAME_H (FRAME_H)
    ) u_counter (
        .clk (clk),
        .rst (rst),
        .x_o (x_w),
        .y_o (y_w)
    );

    raster_axis_classify #(
        .CW     (CW),
        .ACTIVE (ACT_W),
        .PORCH  (H_FP),
        .PULSE  (H_SW)
    ) u_h_axis (
        .clk     (clk),
        .rst     (rst),
        .coord_i (x_w),
        .seg_o   (h_seg)
    );

    raster_axis_classify #(
        .CW     (CW),
        .ACTIVE (ACT_H),
        .PORCH  (V_FP),
        .PULSE  (V_SW)
    ) u_v_axis (
        .clk     (clk),
        .rst     (rst),
        .coord_i (y_w),
        .seg_o   (v_seg)
    );

    raster_strobe_out #(
        .HS_HIGH (HS_HIGH),
        .VS_HIGH (VS_HIGH)
    ) u_strobe (
        .clk     (clk),
        .rst     (rst),
        .h_seg_i (h_seg),
        .v_seg_i (v_seg),
        .hsync_o (hsync),
        .vsync_o (vsync),
        .de_o    (de)
    );

    assign pos_x = x_w;
    assign pos_y = y_w;

    // Pipeline fill since reset, used only to time the alignment checks.
    logic [1:0] fill_q;
    always_ff @(posedge clk) begin
        if (rst) begin
            fill_q <= 2'b00;
        end else begin
            fill_q <= {fill_q[0], 1'b1};
        end
    end

    assert_idle_in_reset_R1: assert property (@(posedge clk)
        $past(rst) |-> (!de && hsync == ~HS_HIGH && vsync == ~VS_HIGH));

    assert_de_align_R7: assert property (@(posedge clk) disable iff (rst)
        fill_q[1] |-> (de == ($past(pos_x, 2) < X_ACT && $past(pos_y, 2) < Y_ACT)));

    assert_hs_align_R5: assert property (@(posedge clk) disable iff (rst)
        fill_q[1] |-> ((hsync == HS_HIGH) ==
                       ($past(pos_x, 2) >= HS_FROM && $past(pos_x, 2) < HS_TO)));

    assert_vs_align_R6: assert property (@(posedge clk) disable iff (rst)
        fill_q[1] |-> ((vsync == VS_HIGH) ==
                       ($past(pos_y, 2) >= VS_FROM && $past(pos_y, 2) < VS_TO)));

endmodule

// File: tb/raster_timing_gen_bench.sv
`timescale 1ns/1ps
module raster_timing_gen_bench;

    localparam int CW = 8;
    // Instance A: non-empty porches, active-high syncs.
    localparam int A_FW = 20, A_FH = 12, A_AW = 12, A_AH = 6;
    localparam int A_HFP = 2, A_HSW = 3, A_VFP = 2, A_VSW = 2;
    // Instance B: empty back porches, active-low syncs.
    localparam int B_FW = 10, B_FH = 8, B_AW = 6, B_AH = 4;
    localparam int B_HFP = 1, B_HSW = 3, B_VFP = 1, B_VSW = 3;
    localparam int SCAN = 480;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic [CW-1:0] xa, ya, xb, yb;
    logic hsa, vsa, dea, hsb, vsb, deb;

    raster_timing_gen #(
        .CW(CW), .FRAME_W(A_FW), .FRAME_H(A_FH), .ACT_W(A_AW), .ACT_H(A_AH),
        .H_FP(A_HFP), .H_SW(A_HSW), .V_FP(A_VFP), .V_SW(A_VSW),
        .HS_HIGH(1'b1), .VS_HIGH(1'b1)
    ) u_raster_timing_gen (
        .clk(clk), .rst(rst), .pos_x(xa), .pos_y(ya),
        .hsync(hsa), .vsync(vsa), .de(dea)
    );

    raster_timing_gen #(
        .CW(CW), .FRAME_W(B_FW), .FRAME_H(B_FH), .ACT_W(B_AW), .ACT_H(B_AH),
        .H_FP(B_HFP), .H_SW(B_HSW), .V_FP(B_VFP), .V_SW(B_VSW),
        .HS_HIGH(1'b0), .VS_HIGH(1'b0)
    ) u_raster_alt (
        .clk(clk), .rst(rst), .pos_x(xb), .pos_y(yb),
        .hsync(hsb), .vsync(vsb), .de(deb)
    );

    int checks = 0;
    int errors = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic test_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk(xa == 0 && ya == 0, "R1 A position in reset", int'(xa) + int'(ya), 0);
        chk(dea == 1'b0, "R1 A de in reset", dea, 0);
        chk(hsa == 1'b0 && vsa == 1'b0, "R1 A syncs inactive", {hsa, vsa}, 0);
        chk(xb == 0 && yb == 0, "R1 B position in reset", int'(xb) + int'(yb), 0);
        chk(deb == 1'b0, "R1 B de in reset", deb, 0);
        chk(hsb == 1'b1, "R8 B hsync idles high when active-low", hsb, 1);
        chk(vsb == 1'b1, "R8 B vsync idles high when active-low", vsb, 1);
    endtask

    task automatic test_latency();
        rst = 1'b0;
        @(negedge clk);
        chk(dea == 1'b0, "R7 A de still at reset level one clock after release", dea, 0);
        chk(xa == 1, "R2 A x stepped once", xa, 1);
        @(negedge clk);
        chk(dea == 1'b1, "R7 A de shows x=0,y=0 two clocks later", dea, 1);
        chk(deb == 1'b1, "R7 B de shows x=0,y=0 two clocks later", deb, 1);
        chk(hsa == 1'b0, "R5 A hsync idle at x=0", hsa, 0);
        // Reset raised mid-line returns everything to the start.
        rst = 1'b1;
        @(negedge clk);
        chk(xa == 0 && ya == 0, "R1 A position cleared by mid-run reset", xa, 0);
        chk(dea == 1'b0, "R1 A de cleared by mid-run reset", dea, 0);
        @(negedge clk);
    endtask

    task automatic test_frames();
        int fw[2], fh[2], aw[2], ah[2], hfp[2], hsw[2], vfp[2], vsw[2];
        bit pol_h[2], pol_v[2];
        int mx[2], my[2], p1x[2], p1y[2], p2x[2], p2y[2];
        int ex_err[2], ey_err[2], de_err[2], hs_err[2], vs_err[2];
        int hs_run[2], vs_run[2], hs_badw[2], vs_badw[2], hs_seen[2], vs_seen[2], de_cnt[2];
        logic [CW-1:0] sx[2], sy[2];
        logic sde[2], shs[2], svs[2];
        fw = '{A_FW, B_FW}; fh = '{A_FH, B_FH}; aw = '{A_AW, B_AW}; ah = '{A_AH, B_AH};
        hfp = '{A_HFP, B_HFP}; hsw = '{A_HSW, B_HSW}; vfp = '{A_VFP, B_VFP}; vsw = '{A_VSW, B_VSW};
        pol_h = '{1'b1, 1'b0}; pol_v = '{1'b1, 1'b0};
        for (int i = 0; i < 2; i++) begin
            mx[i] = 0; my[i] = 0; p1x[i] = 0; p1y[i] = 0; p2x[i] = 0; p2y[i] = 0;
            ex_err[i] = 0; ey_err[i] = 0; de_err[i] = 0; hs_err[i] = 0; vs_err[i] = 0;
            hs_run[i] = 0; vs_run[i] = 0; hs_badw[i] = 0; vs_badw[i] = 0;
            hs_seen[i] = 0; vs_seen[i] = 0; de_cnt[i] = 0;
        end
        rst = 1'b0;
        for (int k = 0; k < SCAN + 2; k++) begin
            sx[0] = xa; sy[0] = ya; sde[0] = dea; shs[0] = hsa; svs[0] = vsa;
            sx[1] = xb; sy[1] = yb; sde[1] = deb; shs[1] = hsb; svs[1] = vsb;
            for (int i = 0; i < 2; i++) begin
                if (k >= 2) begin
                    bit e_de, e_hs, e_vs, act_h, act_v;
                    e_de = (p2x[i] < aw[i]) && (p2y[i] < ah[i]);
                    e_hs = (p2x[i] >= aw[i] + hfp[i]) && (p2x[i] < aw[i] + hfp[i] + hsw[i]);
                    e_vs = (p2y[i] >= ah[i] + vfp[i]) && (p2y[i] < ah[i] + vfp[i] + vsw[i]);
                    if (sde[i] != e_de) de_err[i]++;
                    if (shs[i] != (e_hs ? pol_h[i] : !pol_h[i])) hs_err[i]++;
                    if (svs[i] != (e_vs ? pol_v[i] : !pol_v[i])) vs_err[i]++;
                    if (sde[i]) de_cnt[i]++;
                    act_h = (shs[i] == pol_h[i]);
                    act_v = (svs[i] == pol_v[i]);
                    if (act_h) hs_run[i]++;
                    else if (hs_run[i] > 0) begin
                        if (hs_run[i] != hsw[i]) hs_badw[i]++;
                        hs_seen[i]++; hs_run[i] = 0;
                    end
                    if (act_v) vs_run[i]++;
                    else if (vs_run[i] > 0) begin
                        if (vs_run[i] != vsw[i] * fw[i]) vs_badw[i]++;
                        vs_seen[i]++; vs_run[i] = 0;
                    end
                end
                if (k < SCAN) begin
                    if (int'(sx[i]) != mx[i]) ex_err[i]++;
                    if (int'(sy[i]) != my[i]) ey_err[i]++;
                    p2x[i] = p1x[i]; p2y[i] = p1y[i];
                    p1x[i] = mx[i];  p1y[i] = my[i];
                    if (mx[i] == fw[i] - 1) begin
                        mx[i] = 0;
                        my[i] = (my[i] == fh[i] - 1) ? 0 : my[i] + 1;
                    end else begin
                        mx[i] = mx[i] + 1;
                    end
                end else begin
                    p2x[i] = p1x[i]; p2y[i] = p1y[i];
                end
            end
            @(negedge clk);
        end
        for (int i = 0; i < 2; i++) begin
            chk(ex_err[i] == 0, i == 0 ? "R2 A x sequence" : "R2 B x sequence", ex_err[i], 0);
            chk(ey_err[i] == 0, i == 0 ? "R3 A y sequence" : "R3 B y sequence", ey_err[i], 0);
            chk(de_err[i] == 0, i == 0 ? "R4 A de window" : "R4 B de window", de_err[i], 0);
            chk(hs_err[i] == 0, i == 0 ? "R5 A hsync window" : "R5 B hsync window", hs_err[i], 0);
            chk(vs_err[i] == 0, i == 0 ? "R6 A vsync lines" : "R6 B vsync lines", vs_err[i], 0);
            chk(hs_seen[i] > 0 && hs_badw[i] == 0, i == 0 ? "R9 A hsync width" : "R9 B hsync width",
                hs_badw[i], 0);
            chk(vs_seen[i] > 0 && vs_badw[i] == 0, i == 0 ? "R9 A vsync width" : "R9 B vsync width",
                vs_badw[i], 0);
            chk(de_cnt[i] == (SCAN / (fw[i] * fh[i])) * aw[i] * ah[i],
                i == 0 ? "R9 A active pixels" : "R9 B active pixels",
                de_cnt[i], (SCAN / (fw[i] * fh[i])) * aw[i] * ah[i]);
        end
        chk(hs_seen[1] > 0, "R8 B active-low hsync pulses seen", hs_seen[1], 1);
    endtask

    initial begin
        #(5.0 * 100000);
        errors++;
        $display("FAIL watchdog actual %0d expected %0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        test_reset();
        test_latency();
        test_frames();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule